// File: doc/BRIEF.md
# Multi-Buffer Channel Availability and Watermark Flags

This block models the flag side of a streaming channel whose storage is cut into several equal buffers. An internal producer fills one buffer while an internal consumer drains a different buffer in the same cycles. Each buffer carries one full/empty state bit. The producer sets that bit with a commit strobe. The consumer clears it with a release strobe. The producer index and the consumer index each step round-robin through the buffers.

Toward the external device the block drives two pins. The first is a channel-wide "no buffer can serve you" flag, so it is really a not-available flag. When the external device writes into the channel, the flag asserts only once every buffer is full. When the external device reads from the channel, it asserts only once no buffer holds committed data. The second pin is a byte-level watermark for the buffer on the external side. It gives early notice that the buffer is nearly full, or nearly drained.

Both pins go through a fixed pipeline and a selectable output polarity. The watermark is undefined while the external side moves to its next buffer. During that window the block drives the watermark pin to its inactive level and raises an indicator. The external side should start a transfer from the availability flag and use the watermark only to end one.

Top module: `mbuf_chan_flags`

## Requirements
- R1: With at least two buffers, the producer can write one buffer while the consumer reads another buffer in the same cycles, and the read data is the data committed earlier.
- R2: With dir_in=1 (external side writes), the availability flag stays inactive while at least one buffer is empty. It asserts only when all NUM_BUFS buffers are full.
- R3: With dir_in=1, the flag stays asserted while buffers are only partly read. It deasserts after a release empties one buffer.
- R4: With dir_in=0 (external side reads), the flag asserts when no buffer holds committed data. It deasserts once a commit makes one buffer full.
- R5: A commit marks the producer's buffer full and moves the producer index to the next buffer, wrapping after NUM_BUFS-1. A release marks the consumer's buffer empty and moves the consumer index the same way. Bytes come back in the order they were written, buffer by buffer.
- R6: With pol_high=1, an asserted pin is logic 1. With pol_high=0, an asserted pin is logic 0. The polarity is applied directly at the pin, without delay.
- R7: The flag pins reflect a state change made at clock edge k from edge k+FLAG_DLY onward (FLAG_DLY=2 by default). They still show the old value after edge k+1.
- R8: With dir_in=1, the watermark asserts when the producer's byte count is at least wm_level. With dir_in=0, it asserts when the consumer's buffer is full and its unread byte count is at most wm_level.
- R9: A switch of the external-side buffer (commit when dir_in=1, release when dir_in=0) at edge k raises wm_masked after edges k, k+1 and k+2 (FLAG_DLY+1 cycles). During those cycles wm_pin sits at its inactive level.
- R10: The block ignores a write or a commit when the producer's buffer is full, a commit with no bytes written, and a read or a release when the consumer's buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_in | input | 1 | 1: the external device writes into the channel; 0: it reads from it |
| pol_high | input | 1 | 1: the pins are active-high; 0: active-low |
| wm_level | input | CNT_W | Watermark threshold in bytes |
| prod_valid | input | 1 | Producer byte write |
| prod_data | input | DATA_W | Producer byte |
| prod_commit | input | 1 | Marks the producer's buffer full and advances |
| cons_rd | input | 1 | Consumer byte read |
| cons_release | input | 1 | Marks the consumer's buffer empty and advances |
| cons_data | output | DATA_W | Byte read, registered |
| rdy_pin | output | 1 | Channel not-available flag, after delay and polarity |
| wm_pin | output | 1 | Watermark flag, after delay and polarity, masked while the buffer switches |
| wm_masked | output | 1 | High while the watermark is undefined |

## Verification
The bench fills the channel one buffer at a time. A flag driven from the current buffer only, or with inverted sense, would assert after the first commit rather than the last. It checks the pins one cycle too early and one cycle on time, so a pipeline that is too short or too long shows up. It writes and commits into a full channel, and reads and releases from an empty one, then reads the data back. A design that overwrote a full buffer, or moved its indices on an ignored strobe, would return wrong bytes or no byte. It commits a buffer whose watermark was asserted and samples the pin during the switch, where an unmasked design would still show the stale level.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;

  typedef enum logic {
    XDIR_READS  = 1'b0,
    XDIR_WRITES = 1'b1
  } mbuf_dir_e;

  // Map an internal asserted/deasserted state onto a pin level.
  function automatic logic pin_level(input logic asserted, input logic pol_high);
    return pol_high ? asserted : ~asserted;
  endfunction

endpackage

// File: rtl/mbuf_state.sv
module mbuf_state #(
  parameter int DATA_W    = 8,
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              prod_commit,
  input  logic              cons_rd,
  input  logic              cons_release,
  output logic [NUM_BUFS-1:0] full_o,
  output logic [CNT_W-1:0]  pcnt_o,
  output logic [CNT_W-1:0]  rcnt_o,
  output logic              cfull_o,
  output logic              commit_ok_o,
  output logic              release_ok_o,
  output logic [DATA_W-1:0] cons_data_o
);
  localparam int IDX_W  = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;
  localparam int MEM_D  = NUM_BUFS * BUF_BYTES;
  localparam int ADDR_W = $clog2(MEM_D);

  logic [NUM_BUFS-1:0] full_q, full_d;
  logic [IDX_W-1:0]    pidx_q, pidx_d, cidx_q, cidx_d;
  logic [CNT_W-1:0]    pcnt_q, pcnt_d, rcnt_q, rcnt_d;
  logic [DATA_W-1:0]   mem_q [MEM_D];
  logic [DATA_W-1:0]   data_q;
  logic [ADDR_W-1:0]   waddr, raddr;
  logic                wr_ok, rd_ok, commit_ok, release_ok;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(NUM_BUFS - 1)) ? '0 : idx + IDX_W'(1);
  endfunction

  // Strobe qualification against the per-buffer state bits
  always_comb begin
    wr_ok      = prod_valid && !full_q[pidx_q] && (pcnt_q < CNT_W'(BUF_BYTES));
    commit_ok  = prod_commit && !full_q[pidx_q] && ((pcnt_q != '0) || wr_ok);
    rd_ok      = cons_rd && full_q[cidx_q] && (rcnt_q < CNT_W'(BUF_BYTES));
    release_ok = cons_release && full_q[cidx_q];
    waddr      = ADDR_W'(pidx_q) * ADDR_W'(BUF_BYTES) + ADDR_W'(pcnt_q);
    raddr      = ADDR_W'(cidx_q) * ADDR_W'(BUF_BYTES) + ADDR_W'(rcnt_q);
  end

  // Next state
  always_comb begin
    full_d = full_q;
    pidx_d = pidx_q;
    cidx_d = cidx_q;
    pcnt_d = pcnt_q;
    rcnt_d = rcnt_q;
    if (wr_ok) pcnt_d = pcnt_q + CNT_W'(1);
    if (commit_ok) begin
      full_d[pidx_q] = 1'b1;
      pidx_d         = step_idx(pidx_q);
      pcnt_d         = '0;
    end
    if (rd_ok) rcnt_d = rcnt_q + CNT_W'(1);
    if (release_ok) begin
      full_d[cidx_q] = 1'b0;
      cidx_d         = step_idx(cidx_q);
      rcnt_d         = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      pidx_q <= '0;
      cidx_q <= '0;
      pcnt_q <= '0;
      rcnt_q <= '0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      pidx_q <= pidx_d;
      cidx_q <= cidx_d;
      pcnt_q <= pcnt_d;
      rcnt_q <= rcnt_d;
      if (rd_ok) data_q <= mem_q[raddr];
    end
  end

  // Data array: no reset
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[waddr] <= prod_data;
  end

  assign full_o       = full_q;
  assign pcnt_o       = pcnt_q;
  assign rcnt_o       = rcnt_q;
  assign cfull_o      = full_q[cidx_q];
  assign commit_ok_o  = commit_ok;
  assign release_ok_o = release_ok;
  assign cons_data_o  = data_q;

  // R1: concurrent fill and drain never touch the same buffer
  a_r1_split_buffers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |-> (pidx_q != cidx_q));
  // R5: a commit leaves the committed buffer full and the index moved
  a_r5_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> (full_q[$past(pidx_q)] && (pidx_q != $past(pidx_q))));
  // R5: a release leaves the released buffer empty
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |=> !full_q[$past(cidx_q)]);
  // R10: the producer count does not move while its buffer is full
  a_r10_full_holds_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    full_q[pidx_q] |=> (pcnt_q == $past(pcnt_q)));
endmodule

// File: rtl/mbuf_flag_pipe.sv
module mbuf_flag_pipe #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (i == 0) begin : g_head
      assign stg_d = d_i;
    end else begin : g_tail
      assign stg_d = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d;
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/mbuf_switch_mask.sv
module mbuf_switch_mask #(
  parameter int HOLD = 3,
  localparam int HC_W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance_i,
  output logic masked_o
);
  logic [HC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (advance_i)          cnt_d = HC_W'(HOLD);
    else if (cnt_q != '0)   cnt_d = cnt_q - HC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign masked_o = (cnt_q != '0);

  // R9: a buffer switch opens the mask window on the next cycle
  a_r9_mask_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |=> masked_o);
endmodule

// File: rtl/mbuf_chan_flags.sv
module mbuf_chan_flags
  import mbuf_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MAX_PKT      = 4,
  parameter int PKTS_PER_BUF = 2,
  parameter int NUM_BUFS     = 4,
  parameter int FLAG_DLY     = 2,
  localparam int BUF_BYTES   = MAX_PKT * PKTS_PER_BUF,
  localparam int CNT_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_in,
  input  logic              pol_high,
  input  logic [CNT_W-1:0]  wm_level,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              prod_commit,
  input  logic              cons_rd,
  input  logic              cons_release,
  output logic [DATA_W-1:0] cons_data,
  output logic              rdy_pin,
  output logic              wm_pin,
  output logic              wm_masked
);
  if (NUM_BUFS < 2) begin : g_bad_count
    $error("mbuf_chan_flags needs at least two buffers");
  end
  if (FLAG_DLY < 1) begin : g_bad_dly
    $error("mbuf_chan_flags needs a flag delay of at least one cycle");
  end

  logic [1:0]          rst_sync_q;
  logic                srst_n;
  logic [NUM_BUFS-1:0] full;
  logic [CNT_W-1:0]    pcnt, rcnt;
  logic                cfull, commit_ok, release_ok, advance;
  logic                notavail_raw, wm_raw;
  logic [1:0]          flags_d;
  mbuf_dir_e           xdir;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  mbuf_state #(
    .DATA_W(DATA_W), .NUM_BUFS(NUM_BUFS), .BUF_BYTES(BUF_BYTES)
  ) u_state (
    .clk(clk), .rst_n(srst_n),
    .prod_valid(prod_valid), .prod_data(prod_data), .prod_commit(prod_commit),
    .cons_rd(cons_rd), .cons_release(cons_release),
    .full_o(full), .pcnt_o(pcnt), .rcnt_o(rcnt), .cfull_o(cfull),
    .commit_ok_o(commit_ok), .release_ok_o(release_ok),
    .cons_data_o(cons_data)
  );

  // Channel-wide availability and external-side watermark
  always_comb begin
    xdir = mbuf_dir_e'(dir_in);
    if (xdir == XDIR_WRITES) begin
      notavail_raw = &full;
      wm_raw       = (pcnt >= wm_level);
      advance      = commit_ok;
    end else begin
      notavail_raw = ~|full;
      wm_raw       = cfull && ((CNT_W'(BUF_BYTES) - rcnt) <= wm_level);
      advance      = release_ok;
    end
  end

  mbuf_flag_pipe #(.WIDTH(2), .DEPTH(FLAG_DLY)) u_pipe (
    .clk(clk), .rst_n(srst_n),
    .d_i({wm_raw, notavail_raw}), .q_o(flags_d)
  );

  mbuf_switch_mask #(.HOLD(FLAG_DLY + 1)) u_mask (
    .clk(clk), .rst_n(srst_n), .advance_i(advance), .masked_o(wm_masked)
  );

  assign rdy_pin = pin_level(flags_d[0], pol_high);
  assign wm_pin  = pin_level(flags_d[1] && !wm_masked, pol_high);
endmodule

// File: tb/mbuf_chan_flags_bench.sv
`timescale 1ns/1ps
module mbuf_chan_flags_bench;
  localparam int DW = 8;
  localparam int BB = 8;
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0;
  logic rst_n, dir_in, pol_high, prod_valid, prod_commit, cons_rd, cons_release;
  logic [CW-1:0] wm_level;
  logic [DW-1:0] prod_data, cons_data;
  logic rdy_pin, wm_pin, wm_masked;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbuf_chan_flags u_mbuf_chan_flags (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .pol_high(pol_high),
    .wm_level(wm_level), .prod_valid(prod_valid), .prod_data(prod_data),
    .prod_commit(prod_commit), .cons_rd(cons_rd), .cons_release(cons_release),
    .cons_data(cons_data), .rdy_pin(rdy_pin), .wm_pin(wm_pin), .wm_masked(wm_masked)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic write_bytes(input logic [7:0] base, input int first, input int n);
    for (int i = 0; i < n; i++) begin
      prod_valid = 1'b1;
      prod_data  = base + 8'(first + i);
      tick();
    end
    prod_valid = 1'b0;
  endtask

  task automatic commit_buf();
    prod_commit = 1'b1;
    tick();
    prod_commit = 1'b0;
  endtask

  task automatic read_bytes(input logic [7:0] base, input int first, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cons_rd = 1'b1;
      tick();
      chk({tag, " read byte"}, 32'(cons_data), 32'(base + 8'(first + i)));
    end
    cons_rd = 1'b0;
  endtask

  task automatic release_buf();
    cons_release = 1'b1;
    tick();
    cons_release = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset rdy_pin inactive", 32'(rdy_pin), 32'd0);
    chk("R8 reset wm_pin inactive", 32'(wm_pin), 32'd0);
    chk("R9 reset wm_masked low", 32'(wm_masked), 32'd0);
  endtask

  // Buffer 0: watermark rises at byte 5, mask covers the switch
  task automatic t_watermark_mask();
    write_bytes(8'h00, 0, 4);
    tick(); tick();
    chk("R8 wm below level", 32'(wm_pin), 32'd0);
    write_bytes(8'h00, 4, 1);
    tick(); tick();
    chk("R8 wm at level", 32'(wm_pin), 32'd1);
    write_bytes(8'h00, 5, 3);
    commit_buf();
    chk("R9 masked after switch edge", 32'(wm_masked), 32'd1);
    chk("R9 wm_pin inactive in window", 32'(wm_pin), 32'd0);
    tick();
    chk("R9 masked second cycle", 32'(wm_masked), 32'd1);
    chk("R9 wm_pin inactive second cycle", 32'(wm_pin), 32'd0);
    tick();
    chk("R9 masked third cycle", 32'(wm_masked), 32'd1);
    tick();
    chk("R9 mask window closed", 32'(wm_masked), 32'd0);
    chk("R8 wm low on fresh buffer", 32'(wm_pin), 32'd0);
    chk("R2 one full buffer not asserted", 32'(rdy_pin), 32'd0);
  endtask

  task automatic t_input_fill();
    for (int b = 1; b < 3; b++) begin
      write_bytes(8'(b * 16), 0, BB);
      commit_buf();
      tick(); tick();
      chk("R2 partly full not asserted", 32'(rdy_pin), 32'd0);
    end
    write_bytes(8'h30, 0, BB);
    commit_buf();
    tick();
    chk("R7 flag not yet after one edge", 32'(rdy_pin), 32'd0);
    tick();
    chk("R2 R7 all full asserts", 32'(rdy_pin), 32'd1);
  endtask

  task automatic t_ignore_full();
    write_bytes(8'hEE, 0, 1);
    commit_buf();
    tick(); tick();
    chk("R10 full channel stays asserted", 32'(rdy_pin), 32'd1);
  endtask

  task automatic t_release_input();
    read_bytes(8'h00, 0, BB, "R5 R10 buffer0");
    tick(); tick();
    chk("R3 partly read still asserted", 32'(rdy_pin), 32'd1);
    release_buf();
    tick();
    chk("R3 R7 still asserted one edge later", 32'(rdy_pin), 32'd1);
    tick();
    chk("R3 deasserts after release", 32'(rdy_pin), 32'd0);
  endtask

  task automatic t_polarity();
    pol_high = 1'b0;
    #1;
    chk("R6 active-low deasserted is 1", 32'(rdy_pin), 32'd1);
    pol_high = 1'b1;
    #1;
    chk("R6 active-high deasserted is 0", 32'(rdy_pin), 32'd0);
  endtask

  // Producer fills buffer 0 while consumer drains buffer 1
  task automatic t_concurrent();
    for (int i = 0; i < BB; i++) begin
      prod_valid = 1'b1;
      prod_data  = 8'h40 + 8'(i);
      cons_rd    = 1'b1;
      tick();
      chk("R1 concurrent read byte", 32'(cons_data), 32'(8'h10 + 8'(i)));
    end
    prod_valid   = 1'b0;
    cons_rd      = 1'b0;
    prod_commit  = 1'b1;
    cons_release = 1'b1;
    tick();
    prod_commit  = 1'b0;
    cons_release = 1'b0;
    tick(); tick();
    chk("R1 R5 three full after swap", 32'(rdy_pin), 32'd0);
  endtask

  task automatic t_output_dir();
    dir_in   = 1'b0;
    pol_high = 1'b0;
    wm_level = CW'(3);
    tick(); tick(); tick();
    chk("R4 R6 data present not asserted", 32'(rdy_pin), 32'd1);
    read_bytes(8'h20, 0, BB, "R5 buffer2");
    release_buf();
    read_bytes(8'h30, 0, BB, "R5 buffer3");
    release_buf();
    read_bytes(8'h40, 0, 4, "R1 R5 buffer0");
    tick(); tick();
    chk("R8 out dir 4 left above level", 32'(wm_pin), 32'd1);
    read_bytes(8'h40, 4, 1, "R5 buffer0");
    tick(); tick();
    chk("R8 R6 out dir 3 left asserts low", 32'(wm_pin), 32'd0);
    read_bytes(8'h40, 5, 3, "R5 buffer0");
    release_buf();
    tick();
    chk("R4 R7 not yet after one edge", 32'(rdy_pin), 32'd1);
    tick();
    chk("R4 R6 all empty asserts low", 32'(rdy_pin), 32'd0);
    cons_rd = 1'b1;
    tick();
    cons_rd = 1'b0;
    release_buf();
    tick(); tick();
    chk("R10 empty release keeps asserted", 32'(rdy_pin), 32'd0);
    write_bytes(8'h50, 0, BB);
    commit_buf();
    tick(); tick();
    chk("R4 commit deasserts", 32'(rdy_pin), 32'd1);
    read_bytes(8'h50, 0, 1, "R10 index unmoved by empty release");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dir_in = 1'b1; pol_high = 1'b1; wm_level = CW'(5);
    prod_valid = 1'b0; prod_data = '0; prod_commit = 1'b0;
    cons_rd = 1'b0; cons_release = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick(); tick();
    t_reset();
    t_watermark_mask();
    t_input_fill();
    t_ignore_full();
    t_release_input();
    t_polarity();
    t_concurrent();
    t_output_dir();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule